// File: doc/BRIEF.md
# Timer Channel Output Pin Controller

This block owns the output level of one timer channel's pin inside a multi-channel timer. It takes two single-cycle event pulses, one from the channel's own counter (the primary event) and one from a partner channel (the secondary event). It turns them into a stored level that drives the pin directly. A mode bit selects how the events act. In toggle mode only the secondary event acts, and each pulse inverts the level. In set/reset mode both events act: one drives the level to its active value and the other drives it to its inactive value, and a polarity bit chooses which value is which.

An enable bit decides who owns the level. With the enable set, only events change it and software writes are dropped. With the enable clear, software writes load the level and events are dropped. Software uses this to put the pin at a known level before it starts event-driven output. The stored level is presented on a separate read-back output at all times.

Top module: `tmr_out_pin`

## Requirements
- R1: While `rst_n` is sampled low at a rising clock edge, the level becomes 0 after that edge.
- R2: With `out_en`=1 and `mode_sr`=0 (toggle mode), a `slv_evt` pulse inverts the level at the next edge. `mst_evt` and `pol_inv` have no effect in this mode.
- R3: With `out_en`=1, `mode_sr`=1 and `pol_inv`=0, a lone `mst_evt` sets the level to 1 and a lone `slv_evt` clears it to 0.
- R4: With `out_en`=1, `mode_sr`=1 and `pol_inv`=1, a lone `mst_evt` clears the level to 0 and a lone `slv_evt` sets it to 1.
- R5: In set/reset mode, when `mst_evt` and `slv_evt` are both high in the same cycle, only the `slv_evt` action is applied. The level becomes 0 for `pol_inv`=0 and 1 for `pol_inv`=1.
- R6: With `out_en`=1, a `sw_wr` strobe does not change the level, whatever `sw_wdata` is.
- R7: With `out_en`=0, `sw_wr`=1 loads `sw_wdata` into the level at the next edge. Both event inputs are ignored in this state, including in the same cycle as a write.
- R8: `rd_level` and `out_pin` both show the stored level at all times. They change only one cycle after the inputs that caused the change.
- R9: With no active event, and no write while `out_en`=0, the level holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mst_evt | input | 1 | Primary (own channel) event pulse |
| slv_evt | input | 1 | Secondary (partner channel) event pulse |
| mode_sr | input | 1 | 0 = toggle mode, 1 = set/reset mode |
| pol_inv | input | 1 | Polarity for set/reset mode (0 = primary sets, 1 = primary clears) |
| out_en | input | 1 | 1 = events own the level, 0 = software owns the level |
| sw_wdata | input | 1 | Software write data |
| sw_wr | input | 1 | Software write strobe |
| out_pin | output | 1 | Pin drive, taken directly from the level flop |
| rd_level | output | 1 | Read-back of the stored level |

## Verification
The hardest cases are those where one cycle carries several competing causes. These are a coincident primary and secondary event under each polarity, and a software write arriving together with events under either owner. Each must be checked from both starting levels. From the ports, the only way to set the starting level is a software write with the enable clear. So for every one of the 256 combinations of starting level, mode, polarity, enable, both events, strobe and write data, the bench first preloads the level this way. It then applies the combination for exactly one cycle and compares the level with a value it computes for that combination.

// File: rtl/tmr_out_pin_pkg.sv
package tmr_out_pin_pkg;

    typedef enum logic {
        OM_TOGGLE = 1'b0,
        OM_SETRST = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic lvl;
    } lvl_state_t;

    typedef struct packed {
        logic tgl;
        logic drv_hi;
        logic drv_lo;
    } lvl_req_t;

endpackage

// File: rtl/tmr_out_evt_decode.sv
module tmr_out_evt_decode
    import tmr_out_pin_pkg::*;
(
    input  logic     mst_evt,
    input  logic     slv_evt,
    input  logic     mode_sr,
    input  logic     pol_inv,
    output lvl_req_t req
);

    out_mode_e mode;

    always_comb begin
        mode = out_mode_e'(mode_sr);
        req  = '0;
        if (mode == OM_TOGGLE) begin
            // only the secondary event acts; primary and polarity ignored
            req.tgl = slv_evt;
        end else if (slv_evt) begin
            // secondary event has priority, primary is masked
            req.drv_hi = pol_inv;
            req.drv_lo = ~pol_inv;
        end else if (mst_evt) begin
            req.drv_hi = ~pol_inv;
            req.drv_lo = pol_inv;
        end
    end

endmodule

// File: rtl/tmr_out_lvl_core.sv
module tmr_out_lvl_core
    import tmr_out_pin_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     out_en,
    input  logic     sw_wr,
    input  logic     sw_wdata,
    input  lvl_req_t req,
    output logic     lvl_q
);

    lvl_state_t st_d;
    lvl_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (!out_en) begin
            if (sw_wr) begin
                st_d.lvl = sw_wdata;
            end
        end else if (req.tgl) begin
            st_d.lvl = ~st_q.lvl;
        end else if (req.drv_hi) begin
            st_d.lvl = 1'b1;
        end else if (req.drv_lo) begin
            st_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_q = st_q.lvl;

endmodule

// File: rtl/tmr_out_pin.sv
module tmr_out_pin
    import tmr_out_pin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mst_evt,
    input  logic slv_evt,
    input  logic mode_sr,
    input  logic pol_inv,
    input  logic out_en,
    input  logic sw_wdata,
    input  logic sw_wr,
    output logic out_pin,
    output logic rd_level
);

    lvl_req_t req;
    logic     lvl;

    tmr_out_evt_decode u_decode (
        .mst_evt (mst_evt),
        .slv_evt (slv_evt),
        .mode_sr (mode_sr),
        .pol_inv (pol_inv),
        .req     (req)
    );

    tmr_out_lvl_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .out_en   (out_en),
        .sw_wr    (sw_wr),
        .sw_wdata (sw_wdata),
        .req      (req),
        .lvl_q    (lvl)
    );

    assign out_pin  = lvl;
    assign rd_level = lvl;

endmodule

// File: rtl/tmr_out_pin_chk.sv
module tmr_out_pin_chk (
    input logic clk,
    input logic rst_n,
    input logic mst_evt,
    input logic slv_evt,
    input logic mode_sr,
    input logic pol_inv,
    input logic out_en,
    input logic sw_wdata,
    input logic sw_wr,
    input logic out_pin,
    input logic rd_level
);

    p_reset_low_r1: assert property (@(posedge clk)
        !rst_n |=> !out_pin);

    p_toggle_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !mode_sr && slv_evt) |=> (out_pin != $past(out_pin)));

    p_toggle_master_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && !mode_sr && !slv_evt) |=> $stable(out_pin));

    p_lone_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode_sr && mst_evt && !slv_evt) |=> (out_pin == !$past(pol_inv)));

    p_lone_slave_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode_sr && slv_evt && !mst_evt) |=> (out_pin == $past(pol_inv)));

    p_slave_priority_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode_sr && slv_evt && mst_evt) |=> (out_pin == $past(pol_inv)));

    p_write_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && sw_wr && !mst_evt && !slv_evt) |=> $stable(out_pin));

    p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && sw_wr) |=> (out_pin == $past(sw_wdata)));

    p_readback_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_level == out_pin);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en && !sw_wr) |=> $stable(out_pin));

endmodule

bind tmr_out_pin tmr_out_pin_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mst_evt  (mst_evt),
    .slv_evt  (slv_evt),
    .mode_sr  (mode_sr),
    .pol_inv  (pol_inv),
    .out_en   (out_en),
    .sw_wdata (sw_wdata),
    .sw_wr    (sw_wr),
    .out_pin  (out_pin),
    .rd_level (rd_level)
);

// File: tb/tmr_out_pin_bench.sv
`timescale 1ns/1ps
module tmr_out_pin_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mst_evt = 1'b0;
    logic slv_evt = 1'b0;
    logic mode_sr = 1'b0;
    logic pol_inv = 1'b0;
    logic out_en = 1'b0;
    logic sw_wdata = 1'b0;
    logic sw_wr = 1'b0;
    logic out_pin;
    logic rd_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_out_pin u_tmr_out_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .mst_evt  (mst_evt),
        .slv_evt  (slv_evt),
        .mode_sr  (mode_sr),
        .pol_inv  (pol_inv),
        .out_en   (out_en),
        .sw_wdata (sw_wdata),
        .sw_wr    (sw_wr),
        .out_pin  (out_pin),
        .rd_level (rd_level)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // one cycle: drive at negedge, result visible by the next negedge
    task automatic cycle(input logic m, input logic s, input logic md, input logic p,
                         input logic e, input logic wd, input logic wr);
        mst_evt = m; slv_evt = s; mode_sr = md; pol_inv = p;
        out_en = e; sw_wdata = wd; sw_wr = wr;
        @(negedge clk);
        mst_evt = 0; slv_evt = 0; sw_wr = 0;
    endtask

    function automatic logic model(input logic start, input logic m, input logic s,
                                   input logic md, input logic p, input logic e,
                                   input logic wd, input logic wr);
        if (!e) return wr ? wd : start;
        if (!md) return start ^ s;
        if (s) return p;
        if (m) return ~p;
        return start;
    endfunction

    function automatic string tag_of(input logic m, input logic s, input logic md,
                                     input logic p, input logic e, input logic wr);
        if (!e) return (wr || m || s) ? "R7" : "R9";
        if (!md) return "R2";
        if (m && s) return "R5";
        if (m || s) return p ? "R4" : "R3";
        return wr ? "R6" : "R9";
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R1 reset level", out_pin, 1'b0);
        check("R8 reset readback", rd_level, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 hold after reset", out_pin, 1'b0);

        // exhaustive sweep of all inputs from both start levels
        for (int v = 0; v < 256; v++) begin
            logic st, m, s, md, p, e, wd, wr, exp;
            {st, m, s, md, p, e, wd, wr} = 8'(v);
            cycle(0, 0, 0, 0, 0, st, 1);      // preload through software (R7)
            check("R7 preload", out_pin, st);
            cycle(m, s, md, p, e, wd, wr);
            exp = model(st, m, s, md, p, e, wd, wr);
            check(tag_of(m, s, md, p, e, wr), out_pin, exp);
            check("R8 readback", rd_level, exp);
        end

        // 0% duty: coincident events every cycle keep the level inactive (R5)
        cycle(0, 0, 0, 0, 0, 1, 1);
        for (int k = 0; k < 4; k++) begin
            cycle(1, 1, 1, 0, 1, 0, 0);
            check("R5 zero duty", out_pin, 1'b0);
        end

        // toggle train, then master pulses ignored in toggle mode (R2)
        for (int k = 0; k < 6; k++) begin
            cycle(0, 1, 0, 0, 1, 0, 0);
            check("R2 toggle train", out_pin, k[0] ? 1'b0 : 1'b1);
        end
        cycle(1, 0, 0, 1, 1, 1, 1);
        check("R2 master ignored", out_pin, 1'b0);

        // reset mid-run (R1)
        cycle(1, 0, 1, 0, 1, 0, 0);
        check("R3 set before reset", out_pin, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", out_pin, 1'b0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule